// File: doc/BRIEF.md
# Synchronous Burst SRAM Read Controller

This block is the read side of a synchronous burst static memory. On a clock edge where an address strobe is seen, it captures a base address. A two-bit beat counter then walks through four adjacent words, one word each time the advance input is low. The block merges four chip enables of mixed polarity into one select. It returns each word through a registered data stage, so a word appears one edge after its address is captured or stepped.

There are two active-low address strobes. The controller strobe acts whenever it is low. The processor strobe acts only while the primary enable is low. The write-control input is sampled together with the strobes, and a strobe that arrives with a write asserted starts nothing. The output drive is reported on a flag beside the data, not on a tri-state pin, so that high impedance can be seen directly. The flag needs both the pipelined select and an output enable that was sampled on a clock edge.

The memory contents are a fixed, reset-loaded register file. The word at address `a` is `(a*257) XOR 0x3C5A`, truncated to the data width.

Top module: `sbs_rd_ctrl`

## Requirements
- R1: The block is selected only when, on a strobe edge, `en_main_n`=0, `en_lo_n`=0, `en_hi_a`=1 and `en_hi_b`=1. A strobe edge with any other enable pattern is a deselect cycle.
- R2: A controller-strobe edge with all enables active and `wr_n`=1 loads `addr` as the base. After the following edge, `dout` equals word(base) = low DATA_W bits of `(base*257) ^ 0x3C5A`.
- R3: On each edge where `adv_n`=0 and the block is selected, the beat counter steps. This changes only the two low address bits, by +1 modulo 4, and the upper bits stay at the base value.
- R4: After four beats the burst address returns to the original base. For a base whose low bits are 2, the words appear in the order low bits 2, 3, 0, 1, 2.
- R5: While `adv_n`=1 and no strobe is seen, the address holds and the same word is presented again on each following cycle.
- R6: A strobe during a burst loads a new base, and the burst continues from that new base.
- R7: A strobe edge with `wr_n`=0 starts no read. The address and the select state stay unchanged, so the previous word stays on `dout` with `dout_en`=1.
- R8: The controller strobe takes precedence. With both strobes low and `en_main_n`=1, the edge is a deselect cycle. The processor strobe alone is ignored while `en_main_n`=1.
- R9: After a deselect edge, `dout_en` is still 1 for one cycle and is 0 after the next edge.
- R10: `dout_en` is 1 only when the data stage holds a selected word and `oe_n` was 0 at the latest edge. A change of `oe_n` reaches `dout_en` only after the next rising edge.
- R11: After reset, `dout_en`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, acts only while primary enable is low |
| adv_n | input | 1 | Burst advance, active low |
| wr_n | input | 1 | Write control, active low; a read needs it high |
| en_main_n | input | 1 | Primary chip enable, active low |
| en_lo_n | input | 1 | Extra chip enable, active low |
| en_hi_a | input | 1 | Extra chip enable, active high |
| en_hi_b | input | 1 | Extra chip enable, active high |
| oe_n | input | 1 | Output enable, active low, sampled on the clock |
| addr | input | ADDR_W | Base address captured on a strobe |
| dout | output | DATA_W | Registered read data |
| dout_en | output | 1 | High when the data output would be driven |

## Verification
The burst is started from a base whose low bits are 2. This shows that only the low two bits wrap, and that the sequence returns to the base after four beats instead of running on into the next block. Holding `adv_n` high separates a frozen address from a free-running counter. A second strobe in mid-burst shows the restart. Strobes issued with a write asserted, with one extra enable inactive, and with both strobes low while the primary enable is high separate a load, an ignored strobe and a deselect from one another. Toggling `oe_n` while the block is selected, with the flag sampled both before and after the edge, shows that output drive waits for the clock.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_LOAD,
        CYC_DESEL,
        CYC_WR_BLOCK,
        CYC_ADV
    } cyc_e;

    // Contents of the reset-loaded array row at index a
    function automatic logic [31:0] init_word(input int unsigned a);
        return (a * 32'd257) ^ 32'h0000_3C5A;
    endfunction

endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
    import sbs_pkg::*;
(
    input  logic ctl_strobe_n,
    input  logic cpu_strobe_n,
    input  logic adv_n,
    input  logic wr_n,
    input  logic en_main_n,
    input  logic en_lo_n,
    input  logic en_hi_a,
    input  logic en_hi_b,
    input  logic sel_q,
    output cyc_e kind
);

    logic ctl_hit;
    logic cpu_hit;
    logic en_ok;

    always_comb begin
        ctl_hit = !ctl_strobe_n;
        // processor strobe is disregarded while the primary enable is high
        cpu_hit = !cpu_strobe_n && !en_main_n;
        en_ok   = !en_main_n && !en_lo_n && en_hi_a && en_hi_b;
        if (ctl_hit || cpu_hit) begin
            if (!en_ok)     kind = CYC_DESEL;
            else if (!wr_n) kind = CYC_WR_BLOCK;
            else            kind = CYC_LOAD;
        end else if (!adv_n && sel_q) begin
            kind = CYC_ADV;
        end else begin
            kind = CYC_IDLE;
        end
    end

endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
    import sbs_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BEAT_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              kind,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int HI_W = ADDR_W - BEAT_BITS;

    typedef struct packed {
        logic [ADDR_W-1:0]    base;
        logic [BEAT_BITS-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (kind)
            CYC_LOAD: begin
                st_d.base = addr_in;
                st_d.cnt  = '0;
            end
            CYC_ADV:  st_d.cnt = st_q.cnt + BEAT_BITS'(1);
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = {st_q.base[ADDR_W-1 -: HI_W],
                       st_q.base[BEAT_BITS-1:0] + st_q.cnt};

    assert_load_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_LOAD) |=> (cur_addr == $past(addr_in)));

    assert_adv_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_ADV) |=>
            (cur_addr[BEAT_BITS-1:0] == $past(cur_addr[BEAT_BITS-1:0]) + BEAT_BITS'(1))
            && (cur_addr[ADDR_W-1 -: HI_W] == $past(cur_addr[ADDR_W-1 -: HI_W])));

    assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_IDLE || kind == CYC_WR_BLOCK || kind == CYC_DESEL) |=> $stable(cur_addr));

endmodule

// File: rtl/sbs_regfile.sv
module sbs_regfile
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] rows [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        localparam logic [31:0] INIT = init_word(i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rows[i] <= INIT[DATA_W-1:0];
            else        rows[i] <= rows[i];
        end
    end

    assign rdata = rows[raddr];

endmodule

// File: rtl/sbs_rd_ctrl.sv
module sbs_rd_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int BEAT_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_strobe_n,
    input  logic              cpu_strobe_n,
    input  logic              adv_n,
    input  logic              wr_n,
    input  logic              en_main_n,
    input  logic              en_lo_n,
    input  logic              en_hi_a,
    input  logic              en_hi_b,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    typedef struct packed {
        logic              sel;
        logic              dsel;
        logic              oe;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    cyc_e              kind;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rf_rdata;

    sbs_cycle_decode u_decode (
        .ctl_strobe_n (ctl_strobe_n),
        .cpu_strobe_n (cpu_strobe_n),
        .adv_n        (adv_n),
        .wr_n         (wr_n),
        .en_main_n    (en_main_n),
        .en_lo_n      (en_lo_n),
        .en_hi_a      (en_hi_a),
        .en_hi_b      (en_hi_b),
        .sel_q        (st_q.sel),
        .kind         (kind)
    );

    sbs_burst_addr #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .addr_in  (addr),
        .cur_addr (cur_addr)
    );

    sbs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (cur_addr),
        .rdata (rf_rdata)
    );

    always_comb begin
        st_d = st_q;
        unique case (kind)
            CYC_LOAD:  st_d.sel = 1'b1;
            CYC_DESEL: st_d.sel = 1'b0;
            default:   ;
        endcase
        st_d.dsel  = st_q.sel;
        st_d.oe    = !oe_n;
        st_d.rdata = rf_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.rdata;
    assign dout_en = st_q.dsel && st_q.oe;

    assert_select_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_strobe_n && (en_lo_n || !en_hi_a || !en_hi_b)) |=> !st_q.sel);

    assert_wr_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_strobe_n && !wr_n) |=> $stable(st_q.sel));

    assert_ctl_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_strobe_n && en_main_n) |=> !st_q.sel);

    assert_desel_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.sel |=> !dout_en);

    assert_oe_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dout_en);

endmodule

// File: tb/sbs_rd_ctrl_tb.sv
module sbs_rd_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctl_strobe_n, cpu_strobe_n, adv_n, wr_n;
    logic          en_main_n, en_lo_n, en_hi_a, en_hi_b, oe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbs_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BEAT_BITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_strobe_n(ctl_strobe_n), .cpu_strobe_n(cpu_strobe_n),
        .adv_n(adv_n), .wr_n(wr_n),
        .en_main_n(en_main_n), .en_lo_n(en_lo_n), .en_hi_a(en_hi_a), .en_hi_b(en_hi_b),
        .oe_n(oe_n), .addr(addr), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [DW-1:0] word(input int a);
        logic [31:0] w;
        w = (32'(a) * 32'd257) ^ 32'h3C5A;
        return w[DW-1:0];
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ctl_strobe_n = 1'b1; cpu_strobe_n = 1'b1; adv_n = 1'b1; wr_n = 1'b1;
        en_main_n = 1'b0; en_lo_n = 1'b0; en_hi_a = 1'b1; en_hi_b = 1'b1;
        oe_n = 1'b0; addr = '0;
    endtask

    // controller strobe for one edge, then data is one edge later
    task automatic load(input int a);
        ctl_strobe_n = 1'b0; addr = AW'(a);
        step();
        ctl_strobe_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 1'b0;
        step();
        check("R11 dout_en after reset", 32'(dout_en), 0);
        check("R11 dout after reset", 32'(dout), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_single();
        idle_inputs();
        load(9);
        check("R2 single word", 32'(dout), 32'(word(9)));
        check("R2 driven", 32'(dout_en), 1);
    endtask

    task automatic t_burst_wrap();
        int exp_lo[5] = '{2, 3, 0, 1, 2};
        idle_inputs();
        ctl_strobe_n = 1'b0; addr = AW'(6'h2E);
        step();
        ctl_strobe_n = 1'b1; adv_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            check(i < 4 ? "R3 burst beat" : "R4 wrap to base",
                  32'(dout), 32'(word((6'h2E & 6'h3C) | exp_lo[i])));
        end
        adv_n = 1'b1;
    endtask

    task automatic t_hold();
        idle_inputs();
        load(6'h11);
        step();
        check("R5 hold repeat 1", 32'(dout), 32'(word(6'h11)));
        step();
        check("R5 hold repeat 2", 32'(dout), 32'(word(6'h11)));
        adv_n = 1'b0;
        step();
        adv_n = 1'b1;
        step();
        check("R5 resume step", 32'(dout), 32'(word(6'h12)));
    endtask

    task automatic t_restart();
        idle_inputs();
        ctl_strobe_n = 1'b0; addr = AW'(6'h04);
        step();
        ctl_strobe_n = 1'b1; adv_n = 1'b0;
        step();
        step();
        check("R6 first burst beat", 32'(dout), 32'(word(6'h05)));
        // processor strobe restarts from a new base mid-burst
        cpu_strobe_n = 1'b0; addr = AW'(6'h33);
        step();
        cpu_strobe_n = 1'b1;
        step();
        check("R6 new base", 32'(dout), 32'(word(6'h33)));
        step();
        check("R6 continues from new base", 32'(dout), 32'(word(6'h30)));
        adv_n = 1'b1;
    endtask

    task automatic t_write_block();
        idle_inputs();
        load(6'h20);
        ctl_strobe_n = 1'b0; wr_n = 1'b0; addr = AW'(6'h15);
        step();
        ctl_strobe_n = 1'b1; wr_n = 1'b1;
        step();
        check("R7 write strobe no load", 32'(dout), 32'(word(6'h20)));
        check("R7 still driven", 32'(dout_en), 1);
    endtask

    task automatic t_priority();
        idle_inputs();
        load(6'h08);
        // processor strobe alone while primary enable high: ignored
        cpu_strobe_n = 1'b0; en_main_n = 1'b1; addr = AW'(6'h3F);
        step();
        cpu_strobe_n = 1'b1; en_main_n = 1'b0;
        step();
        check("R8 processor strobe ignored", 32'(dout), 32'(word(6'h08)));
        check("R8 still selected", 32'(dout_en), 1);
        // both strobes with primary enable high: controller wins, deselect
        ctl_strobe_n = 1'b0; cpu_strobe_n = 1'b0; en_main_n = 1'b1;
        step();
        ctl_strobe_n = 1'b1; cpu_strobe_n = 1'b1; en_main_n = 1'b0;
        step();
        check("R8 controller strobe deselects", 32'(dout_en), 0);
    endtask

    task automatic t_deselect();
        idle_inputs();
        load(6'h0C);
        ctl_strobe_n = 1'b0; en_hi_a = 1'b0;
        step();
        ctl_strobe_n = 1'b1; en_hi_a = 1'b1;
        check("R9 driven one more cycle", 32'(dout_en), 1);
        step();
        check("R1 extra enable low deselects", 32'(dout_en), 0);
        load(6'h0C);
        ctl_strobe_n = 1'b0; en_lo_n = 1'b1;
        step();
        ctl_strobe_n = 1'b1; en_lo_n = 1'b0;
        step();
        check("R1 low-active extra enable high deselects", 32'(dout_en), 0);
    endtask

    task automatic t_oe();
        idle_inputs();
        oe_n = 1'b1;
        load(6'h1A);
        check("R10 oe high not driven", 32'(dout_en), 0);
        oe_n = 1'b0;
        #1;
        check("R10 oe waits for edge", 32'(dout_en), 0);
        step();
        check("R10 oe after edge", 32'(dout_en), 1);
        oe_n = 1'b1;
        step();
        check("R10 oe released", 32'(dout_en), 0);
        oe_n = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst_wrap();
        t_hold();
        t_restart();
        t_write_block();
        t_priority();
        t_deselect();
        t_oe();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule